// File: doc/BRIEF.md
# Cost-Aware LRU Victim Selector

This block decides which way of a set-associative cache set is replaced when a miss arrives. It keeps a true-LRU recency order for every set, and it also weighs a per-way miss cost and confidence bit supplied with the miss. A way whose recorded cost is above a programmable threshold and whose confidence bit is set counts as cheap to lose. Cheap ways are evicted first, so expensive blocks stay resident while they are still being reused.

On each miss the selector applies three rules in priority order. An empty (invalid) way is always filled first, the lowest-numbered one. Otherwise, if any cheap ways exist, one of them is chosen pseudo-randomly. Otherwise the least recently used way is evicted. Hits and fills are reported on a separate access port, which moves the touched way to the most recently used position. The victim is presented as both an encoded index and a one-hot vector, with a one-cycle valid strobe.

Top module: `cost_lru_victim_sel`

## Requirements
- R1: After reset `vic_valid` is 0, the threshold is 16, and every set's recency order makes way N-1 the least recently used and way 0 the most recently used.
- R2: `vic_valid` is 1 in exactly the cycle after a cycle with `miss_valid` = 1 and 0 otherwise; while it is 1, `vic_onehot` has exactly one bit set, at position `vic_way`.
- R3: If any bit of `miss_line_valid` is 0, the victim is the lowest-numbered way whose bit is 0, regardless of cost or recency.
- R4: A way is low-cost when its 5-bit cost field (way w at bits [5w+4:5w] of `miss_cost`) is strictly greater than the threshold and its `miss_conf` bit is 1; a cost equal to the threshold or a confidence bit of 0 does not qualify.
- R5: With all ways valid and at least one low-cost way, the victim is always a low-cost way, and repeated misses on the same set reach every low-cost way (a 16-bit maximal-length LFSR advancing every cycle, with its low byte taken modulo the candidate count, indexes the candidates in way order).
- R6: With all ways valid and no low-cost way, the victim is the least recently used way of `miss_set`.
- R7: An access on `acc_set`/`acc_way` makes that way most recently used; ways that were more recent than it age by one and the others keep their position.
- R8: A write with `thr_we` = 1 loads `thr_wdata` into the threshold at that clock edge; misses in later cycles use the new value.
- R9: When an access and a miss hit the same set in the same cycle, the miss sees the recency order from before that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| thr_we | input | 1 | Threshold write enable |
| thr_wdata | input | 5 | New threshold value |
| acc_valid | input | 1 | Hit or fill notification |
| acc_set | input | 4 | Set of the access |
| acc_way | input | 3 | Way made most recently used |
| miss_valid | input | 1 | Miss request, victim wanted |
| miss_set | input | 4 | Set of the miss |
| miss_line_valid | input | 8 | Valid bit per way of the set |
| miss_conf | input | 8 | Cost confidence bit per way |
| miss_cost | input | 40 | Cost per way, 5 bits each, way 0 in the low bits |
| vic_valid | output | 1 | Victim result strobe |
| vic_way | output | 3 | Encoded victim way |
| vic_onehot | output | 8 | One-hot victim way |

## Verification
Directed misses separate the three rules: sets with holes in the valid vector (with cheap ways present too) show invalid-first priority, costs equal to and one above the threshold and cheap costs with confidence cleared probe the low-cost test, and fully valid sets of expensive blocks expose the recency order after chosen access sequences. A repeated-miss run over a fixed set of three cheap ways shows the random choice stays inside the candidates and reaches each of them. Random traffic mixes accesses, misses, threshold writes and partly valid sets, with the bench keeping its own recency model, and a same-cycle access-and-miss case tells whether the miss reads the order before or after the update.

// File: rtl/cav_pkg.sv
// Shared types for the cost-aware victim selector.
package cav_pkg;
    // Which rule produced a victim.
    typedef enum logic [1:0] {
        VK_INVALID = 2'd0,
        VK_LOWCOST = 2'd1,
        VK_LRU     = 2'd2
    } vic_kind_e;
endpackage

// File: rtl/cav_lfsr.sv
// Free-running Fibonacci LFSR.
// Assumes TAPS describes a maximal-length polynomial for WIDTH and SEED != 0.
// Exposes only the low OUT_W bits used for random selection.
module cav_lfsr #(
    parameter int WIDTH = 16,
    parameter logic [WIDTH-1:0] TAPS = 16'hB400,
    parameter logic [WIDTH-1:0] SEED = 16'hACE1,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);
    logic [WIDTH-1:0] q;

    // Shift in the XOR of the tapped bits every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[WIDTH-2:0], ^(q & TAPS)};
    end

    assign rnd_o = q[OUT_W-1:0];

    assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/cav_age_store.sv
// Per-set true-LRU recency kept as ordered ages (0 = MRU, NUM_WAYS-1 = LRU).
// Assumes NUM_WAYS is a power of two; each set's ages stay a permutation.
// Read port is combinational, so a same-cycle touch is not visible to it.
module cav_age_store #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 8,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_valid,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAY_W-1:0] lru_way
);
    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(NUM_WAYS - 1);

    logic [WAY_W-1:0] age_q [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] max_hit;

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            // Touched way goes to age 0; younger ways than it age by one.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    age_q[s][w] <= WAY_W'(w);
                end else if (touch_valid && touch_set == SET_W'(s)) begin
                    if (touch_way == WAY_W'(w))
                        age_q[s][w] <= '0;
                    else if (age_q[s][w] < age_q[s][touch_way])
                        age_q[s][w] <= age_q[s][w] + WAY_W'(1);
                end
            end

            assert_touch_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
                touch_valid && touch_set == SET_W'(s) && touch_way == WAY_W'(w)
                |=> age_q[s][w] == '0);
        end
    end

    // Find the way holding the oldest age in the read set.
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            max_hit[w] = (age_q[rd_set][w] == OLDEST);
            if (max_hit[w]) lru_way = WAY_W'(w);
        end
    end

    assert_lru_unique_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(max_hit));
endmodule

// File: rtl/cav_pick.sv
// Combinational victim choice for one set: invalid first (lowest index),
// then a random low-cost way, then the LRU way.
// Assumes rnd carries fresh pseudo-random bits each cycle.
module cav_pick
    import cav_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int COST_W = 5,
    parameter int RND_W = 8,
    localparam int WAY_W = $clog2(NUM_WAYS),
    localparam int CNT_W = WAY_W + 1
) (
    input  logic [NUM_WAYS*COST_W-1:0] cost,
    input  logic [NUM_WAYS-1:0]        conf,
    input  logic [NUM_WAYS-1:0]        line_valid,
    input  logic [COST_W-1:0]          thr,
    input  logic [RND_W-1:0]           rnd,
    input  logic [WAY_W-1:0]           lru_way,
    output logic [NUM_WAYS-1:0]        low_mask,
    output logic [WAY_W-1:0]           pick_way,
    output vic_kind_e                  pick_kind
);
    logic [CNT_W-1:0] n_low;
    logic [RND_W-1:0] rank_full;
    logic [CNT_W-1:0] rank;
    logic [CNT_W-1:0] seen;
    logic [WAY_W-1:0] inv_way;
    logic [WAY_W-1:0] low_way;

    // Classify ways and count the low-cost candidates.
    always_comb begin
        n_low = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            low_mask[w] = conf[w] && (cost[w*COST_W +: COST_W] > thr);
            if (low_mask[w]) n_low = n_low + CNT_W'(1);
        end
    end

    // Reduce the random byte to a rank among the candidates.
    always_comb begin
        rank_full = (n_low == '0) ? '0 : rnd % RND_W'(n_low);
        rank      = rank_full[CNT_W-1:0];
    end

    // Locate the rank-th candidate in way order.
    always_comb begin
        seen    = '0;
        low_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (low_mask[w]) begin
                if (seen == rank) low_way = WAY_W'(w);
                seen = seen + CNT_W'(1);
            end
        end
    end

    // Lowest-numbered invalid way wins; scan downward so the last hit is lowest.
    always_comb begin
        inv_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--)
            if (!line_valid[w]) inv_way = WAY_W'(w);
    end

    // Apply the rule priority.
    always_comb begin
        if (!(&line_valid)) begin
            pick_kind = VK_INVALID;
            pick_way  = inv_way;
        end else if (|low_mask) begin
            pick_kind = VK_LOWCOST;
            pick_way  = low_way;
        end else begin
            pick_kind = VK_LRU;
            pick_way  = lru_way;
        end
    end
endmodule

// File: rtl/cost_lru_victim_sel.sv
// Top: holds the cost threshold, the per-set recency and the LFSR, and
// registers the chosen victim one cycle after each miss request.
// Assumes fills and hits are reported on the access port by the cache.
module cost_lru_victim_sel
    import cav_pkg::*;
#(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 8,
    parameter int COST_W = 5,
    parameter int THR_RESET = 16,
    parameter int LFSR_W = 16,
    parameter int RND_W = 8,
    localparam int SET_W = $clog2(NUM_SETS),
    localparam int WAY_W = $clog2(NUM_WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       thr_we,
    input  logic [COST_W-1:0]          thr_wdata,
    input  logic                       acc_valid,
    input  logic [SET_W-1:0]           acc_set,
    input  logic [WAY_W-1:0]           acc_way,
    input  logic                       miss_valid,
    input  logic [SET_W-1:0]           miss_set,
    input  logic [NUM_WAYS-1:0]        miss_line_valid,
    input  logic [NUM_WAYS-1:0]        miss_conf,
    input  logic [NUM_WAYS*COST_W-1:0] miss_cost,
    output logic                       vic_valid,
    output logic [WAY_W-1:0]           vic_way,
    output logic [NUM_WAYS-1:0]        vic_onehot
);
    logic [COST_W-1:0]   thr_q;
    logic [RND_W-1:0]    rnd;
    logic [WAY_W-1:0]    lru_way;
    logic [NUM_WAYS-1:0] low_mask;
    logic [WAY_W-1:0]    pick_way;
    vic_kind_e           pick_kind;

    // Programmable low-cost threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr_q <= COST_W'(THR_RESET);
        else if (thr_we) thr_q <= thr_wdata;
    end

    cav_lfsr #(.WIDTH(LFSR_W), .OUT_W(RND_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );

    cav_age_store #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_ages (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_valid (acc_valid),
        .touch_set   (acc_set),
        .touch_way   (acc_way),
        .rd_set      (miss_set),
        .lru_way     (lru_way)
    );

    cav_pick #(.NUM_WAYS(NUM_WAYS), .COST_W(COST_W), .RND_W(RND_W)) u_pick (
        .cost       (miss_cost),
        .conf       (miss_conf),
        .line_valid (miss_line_valid),
        .thr        (thr_q),
        .rnd        (rnd),
        .lru_way    (lru_way),
        .low_mask   (low_mask),
        .pick_way   (pick_way),
        .pick_kind  (pick_kind)
    );

    // Register the victim and its strobe one cycle after the miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vic_valid  <= 1'b0;
            vic_way    <= '0;
            vic_onehot <= '0;
        end else begin
            vic_valid <= miss_valid;
            if (miss_valid) begin
                vic_way    <= pick_way;
                vic_onehot <= NUM_WAYS'(1) << pick_way;
            end
        end
    end

    assert_vic_follows_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |=> vic_valid);
    assert_vic_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |=> !vic_valid);
    assert_vic_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vic_valid |-> ($onehot(vic_onehot) && vic_onehot[vic_way]));
    assert_invalid_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && !(&miss_line_valid)
        |-> (pick_kind == VK_INVALID && !miss_line_valid[pick_way]));
    assert_lowcost_member_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && pick_kind == VK_LOWCOST |-> low_mask[pick_way]);
    assert_thr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        thr_we |=> thr_q == $past(thr_wdata));
endmodule

// File: tb/tb_cost_lru_victim_sel.sv
module tb_cost_lru_victim_sel;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 16;
    localparam int NW = 8;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          thr_we = 1'b0;
    logic [CW-1:0] thr_wdata = '0;
    logic          acc_valid = 1'b0;
    logic [3:0]    acc_set = '0;
    logic [2:0]    acc_way = '0;
    logic          miss_valid = 1'b0;
    logic [3:0]    miss_set = '0;
    logic [NW-1:0] miss_line_valid = '1;
    logic [NW-1:0] miss_conf = '0;
    logic [NW*CW-1:0] miss_cost = '0;
    logic          vic_valid;
    logic [2:0]    vic_way;
    logic [NW-1:0] vic_onehot;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int m_age [NS][NW];
    int m_thr;
    int last_way;

    cost_lru_victim_sel dut (
        .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .acc_valid(acc_valid), .acc_set(acc_set), .acc_way(acc_way),
        .miss_valid(miss_valid), .miss_set(miss_set),
        .miss_line_valid(miss_line_valid), .miss_conf(miss_conf),
        .miss_cost(miss_cost), .vic_valid(vic_valid), .vic_way(vic_way),
        .vic_onehot(vic_onehot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NW-1:0] low_of(input logic [NW*CW-1:0] c,
                                             input logic [NW-1:0] cf, input int thr);
        logic [NW-1:0] m;
        for (int w = 0; w < NW; w++) m[w] = cf[w] && (int'(c[w*CW +: CW]) > thr);
        return m;
    endfunction

    function automatic int lru_of(input int s);
        for (int w = 0; w < NW; w++) if (m_age[s][w] == NW-1) return w;
        return -1;
    endfunction

    function automatic void touch(input int s, input int w);
        int a = m_age[s][w];
        for (int k = 0; k < NW; k++) if (m_age[s][k] < a) m_age[s][k]++;
        m_age[s][w] = 0;
    endfunction

    // Inputs are already driven (after a negedge); run one edge, check, update model.
    task automatic run_cycle();
        int kind = 0, exp_way = 0;
        logic [NW-1:0] low;
        bit mv = miss_valid;
        low = low_of(miss_cost, miss_conf, m_thr);
        if (mv) begin
            if (!(&miss_line_valid)) begin
                kind = 0;
                for (int w = NW-1; w >= 0; w--) if (!miss_line_valid[w]) exp_way = w;
            end else if (low != 0) kind = 1;
            else begin kind = 2; exp_way = lru_of(int'(miss_set)); end
        end
        @(posedge clk); #1;
        check(vic_valid == mv, "R2 strobe", int'(vic_valid), int'(mv));
        if (mv) begin
            check(vic_onehot == (NW'(1) << vic_way), "R2 onehot", int'(vic_onehot), 1 << vic_way);
            if (kind == 0) check(int'(vic_way) == exp_way, "R3 invalid first", int'(vic_way), exp_way);
            if (kind == 1) check(low[vic_way] == 1'b1, "R5 low-cost member", int'(vic_way), int'(low));
            if (kind == 2) check(int'(vic_way) == exp_way, "R6 lru", int'(vic_way), exp_way);
            last_way = int'(vic_way);
        end
        if (acc_valid) touch(int'(acc_set), int'(acc_way));
        if (thr_we) m_thr = int'(thr_wdata);
        @(negedge clk);
        miss_valid = 1'b0; acc_valid = 1'b0; thr_we = 1'b0;
    endtask

    task automatic miss(input int s, input logic [NW-1:0] lv,
                        input logic [NW-1:0] cf, input logic [NW*CW-1:0] c);
        miss_valid = 1'b1; miss_set = 4'(s);
        miss_line_valid = lv; miss_conf = cf; miss_cost = c;
    endtask

    function automatic logic [NW*CW-1:0] one_cost(input int w, input int v, input int rest);
        logic [NW*CW-1:0] c;
        for (int k = 0; k < NW; k++) c[k*CW +: CW] = CW'((k == w) ? v : rest);
        return c;
    endfunction

    initial begin
        int cnt [NW];
        void'($urandom(32'd20240611));
        for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) m_age[s][w] = w;
        m_thr = 16;
        repeat (3) @(negedge clk);
        check(vic_valid == 1'b0, "R1 reset strobe", int'(vic_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(vic_valid == 1'b0, "R1 idle after reset", int'(vic_valid), 0);

        // R1: reset recency makes way 7 the LRU.
        miss(0, '1, '0, '0); run_cycle();
        check(last_way == 7, "R1 reset lru", last_way, 7);
        // R4: cost equal to the reset threshold is not low-cost.
        miss(0, '1, '1, one_cost(0, 16, 16)); run_cycle();
        check(last_way == 7, "R4 equal cost", last_way, 7);
        miss(0, '1, '1, one_cost(2, 17, 16)); run_cycle();
        check(last_way == 2, "R4 above threshold", last_way, 2);
        miss(0, '1, 8'b1101_1111, one_cost(5, 31, 0)); run_cycle();
        check(last_way == 7, "R4 no confidence", last_way, 7);
        // R3: holes win even with a low-cost way present.
        miss(0, 8'b1110_0101, '1, one_cost(2, 31, 0)); run_cycle();
        check(last_way == 1, "R3 lowest hole", last_way, 1);
        // R7: touches reorder recency.
        acc_valid = 1; acc_set = 0; acc_way = 7; run_cycle();
        miss(0, '1, '0, '0); run_cycle();
        check(last_way == 6, "R7 after touch 7", last_way, 6);
        acc_valid = 1; acc_set = 0; acc_way = 6; run_cycle();
        miss(0, '1, '0, '0); run_cycle();
        check(last_way == 5, "R7 after touch 6", last_way, 5);
        // R8: new threshold applies to later misses.
        thr_we = 1; thr_wdata = 5'd30; run_cycle();
        miss(0, '1, '1, one_cost(3, 30, 0)); run_cycle();
        check(last_way == 5, "R8 cost at new threshold", last_way, 5);
        miss(0, '1, '1, one_cost(3, 31, 0)); run_cycle();
        check(last_way == 3, "R8 cost above new threshold", last_way, 3);
        thr_we = 1; thr_wdata = 5'd16; run_cycle();
        // R5: repeated misses reach all three cheap ways (1, 4, 6).
        for (int w = 0; w < NW; w++) cnt[w] = 0;
        for (int i = 0; i < 60; i++) begin
            logic [NW*CW-1:0] c = '0;
            c[1*CW +: CW] = 5'd31; c[4*CW +: CW] = 5'd31; c[6*CW +: CW] = 5'd31;
            miss(1, '1, '1, c); run_cycle();
            cnt[last_way]++;
        end
        check(cnt[1] > 0 && cnt[4] > 0 && cnt[6] > 0, "R5 all candidates reached",
              cnt[1] * 10000 + cnt[4] * 100 + cnt[6], 1);
        check(cnt[1] + cnt[4] + cnt[6] == 60, "R5 only candidates", cnt[1] + cnt[4] + cnt[6], 60);
        // R9: same-cycle access and miss on set 3 sees old order.
        acc_valid = 1; acc_set = 3; acc_way = 7;
        miss(3, '1, '0, '0); run_cycle();
        check(last_way == 7, "R9 miss sees old order", last_way, 7);
        miss(3, '1, '0, '0); run_cycle();
        check(last_way == 6, "R9 update visible next", last_way, 6);

        // Random mix (R2, R3, R5, R6, R7, R8 checked inside run_cycle).
        for (int i = 0; i < 600; i++) begin
            if ($urandom_range(0, 1) == 1) begin
                acc_valid = 1; acc_set = 4'($urandom); acc_way = 3'($urandom);
            end
            if ($urandom_range(0, 19) == 0) begin
                thr_we = 1; thr_wdata = 5'($urandom);
            end
            if ($urandom_range(0, 1) == 1) begin
                logic [NW*CW-1:0] c;
                for (int w = 0; w < NW; w++) c[w*CW +: CW] = 5'($urandom);
                miss(int'($urandom_range(0, NS-1)),
                     ($urandom_range(0, 3) == 0) ? NW'($urandom) : '1,
                     NW'($urandom), c);
            end
            run_cycle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule